// File: doc/BRIEF.md
# Reordered-Tap Direct-Form FIR Engine

The block is a direct-form FIR filter with a single multiplier. One multiply-accumulate unit is shared by all taps over a period of N clock cycles. A new input sample is taken in at most once per period, and one filtered, rounded and saturated output comes out per period. The sample history sits in a circular ring of N words. The ring is written once per period and read once per cycle. The coefficients come from a ROM that is built at elaboration time.

The taps are not visited in index order. A step-indexed order table picks the coefficient address for each step. A second table picks the sample delay that pairs with that coefficient. The read address for that sample is formed as the newest write slot minus the delay, modulo N. The permutation is a constant, typically chosen offline so that successive coefficients differ in few bits, which cuts switching in the multiplier. The full-width accumulator makes the sum exact, so the output is bit-identical to a filter that visits the taps in index order.

Top module: `reord_fir`

## Requirements
- R1: After reset, inReady is 1 and busy, outValid and outData are 0.
- R2: A sample is taken on a rising edge where inValid and inReady are both 1. inReady is 0 during steps 0 to N-2 of a busy period. inValid and inData have no effect while inReady is 0.
- R3: outValid is a single-cycle pulse. It is high in the N-th cycle after the accepting edge, which is the cycle that follows the edge ending step N-1.
- R4: outData equals sat((S + 2^(FRAC-1)) >>> FRAC), where S = sum over j=0..N-1 of h[j]*x[n-j] in full precision. The defaults are N=24, 16-bit samples and coefficients, and FRAC=15.
- R5: The coefficient of tap j is h[j] = ((j*7919 + 1234) mod 20001) - 10000.
- R6: At step s the engine uses the tap t = (s*ORD_MUL + ORD_OFS) mod N (defaults 7 and 5, with ORD_MUL coprime to N). It reads h[t] and the sample with delay t. The result is bit-identical to processing the taps in index order.
- R7: Ring entries that have not been written since reset read as zero.
- R8: A sample offered on the last step is accepted at once, so back-to-back input gives one output every N cycles.
- R9: Results above 2^(DW-1)-1 or below -2^(DW-1) clamp to those limits.
- R10: busy is 1 from the accepting edge until the edge that ends step N-1. It stays high on that edge if a new sample is taken at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An input sample is offered |
| inData | input | DW | Signed input sample |
| inReady | output | 1 | The engine can take a sample on this edge |
| outValid | output | 1 | One-cycle strobe for a new result |
| outData | output | DW | Signed, rounded, saturated result |
| busy | output | 1 | A period of multiply-accumulate steps is running |

## Verification
The first pattern is a single impulse followed by zeros. It reads the coefficients back in index order, so any permutation slot that visits a tap twice or skips one shows up at once. It also checks the zero history after reset. A signed random stream, fed back-to-back and with idle gaps, separates errors in the ring addressing from errors in the period handshake. Blocks of samples whose signs match the coefficient signs drive the sum past both limits, which tests saturation and rounding of negative sums. Junk offered while the engine is busy must leave every later output unchanged.

// File: rtl/reord_fir_pkg.sv
package reord_fir_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // write the accepted sample into the ring
    logic mac;    // a multiply-accumulate step is running
    logic first;  // step 0: restart the sum
    logic last;   // step N-1: round and register the result
  } firStrobe_t;

  // Tap visited at a given step (a permutation when mul is coprime to n).
  function automatic int tapOfStep(int s, int n, int mul, int ofs);
    return (s * mul + ofs) % n;
  endfunction

  // Coefficient value of tap j.
  function automatic int coefOfTap(int j);
    return ((j * 7919 + 1234) % 20001) - 10000;
  endfunction

endpackage

// File: rtl/reord_fir_ctrl.sv
module reord_fir_ctrl
  import reord_fir_pkg::*;
#(
  parameter int NTAPS = 24,
  localparam int AW = $clog2(NTAPS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output logic          busy,
  output logic [AW-1:0] stepIdx,
  output firStrobe_t    strobe
);

  localparam logic [AW-1:0] LAST_STEP = AW'(NTAPS - 1);

  logic onLast;
  logic accept;

  assign onLast  = busy && (stepIdx == LAST_STEP);
  assign inReady = !busy || onLast;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.load  = accept;
    strobe.mac   = busy;
    strobe.first = busy && (stepIdx == '0);
    strobe.last  = onLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepIdx <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      stepIdx <= '0;
    end else if (onLast) begin
      busy    <= 1'b0;
      stepIdx <= '0;
    end else if (busy) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

endmodule

// File: rtl/reord_fir_order_lut.sv
module reord_fir_order_lut
  import reord_fir_pkg::*;
#(
  parameter int NTAPS   = 24,
  parameter int ORD_MUL = 7,
  parameter int ORD_OFS = 5,
  localparam int AW = $clog2(NTAPS)
) (
  input  logic [AW-1:0] stepIdx,
  output logic [AW-1:0] coefAddr,
  output logic [AW-1:0] sampleOfs
);

  logic [AW-1:0] coefTab [NTAPS];
  logic [AW-1:0] ofsTab  [NTAPS];

  // Two tables: one addresses the coefficient ROM, one names the sample delay.
  for (genvar g = 0; g < NTAPS; g++) begin : g_tab
    assign coefTab[g] = AW'(tapOfStep(g, NTAPS, ORD_MUL, ORD_OFS));
    assign ofsTab[g]  = AW'(tapOfStep(g, NTAPS, ORD_MUL, ORD_OFS));
  end

  assign coefAddr  = coefTab[stepIdx];
  assign sampleOfs = ofsTab[stepIdx];

endmodule

// File: rtl/reord_fir_coef_rom.sv
module reord_fir_coef_rom
  import reord_fir_pkg::*;
#(
  parameter int NTAPS = 24,
  parameter int CW    = 16,
  localparam int AW = $clog2(NTAPS)
) (
  input  logic [AW-1:0] addr,
  output logic [CW-1:0] coef
);

  logic [CW-1:0] romWord [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_rom
    assign romWord[g] = CW'(coefOfTap(g));
  end

  assign coef = romWord[addr];

endmodule

// File: rtl/reord_fir_datapath.sv
module reord_fir_datapath
  import reord_fir_pkg::*;
#(
  parameter int NTAPS = 24,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 15,
  localparam int AW   = $clog2(NTAPS),
  localparam int PW   = DW + CW,
  localparam int ACCW = PW + AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  firStrobe_t    strobe,
  input  logic [DW-1:0] inData,
  input  logic [AW-1:0] coefAddr,
  input  logic [AW-1:0] sampleOfs,
  output logic          outValid,
  output logic [DW-1:0] outData
);

  localparam logic [ACCW:0] HALF = (ACCW + 1)'(1) << (FRAC - 1);

  logic [DW-1:0] ring [NTAPS];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] curPtr;
  logic [AW-1:0] rdAddr;
  logic [DW-1:0] sampleWord;
  logic [CW-1:0] coefWord;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prodExt;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] sumNext;
  logic signed [ACCW:0]   rnd;
  logic signed [ACCW:0]   shifted;
  logic [DW-1:0]          satVal;

  reord_fir_coef_rom #(.NTAPS(NTAPS), .CW(CW)) u_rom (
    .addr(coefAddr),
    .coef(coefWord)
  );

  // Ring read address: newest slot minus the delay, modulo N.
  always_comb begin
    int diff;
    diff = int'(curPtr) - int'(sampleOfs);
    if (diff < 0) diff = diff + NTAPS;
    rdAddr = AW'(diff);
  end

  assign sampleWord = ring[rdAddr];
  assign prod       = $signed(sampleWord) * $signed(coefWord);
  assign prodExt    = {{(ACCW - PW){prod[PW-1]}}, prod};
  assign sumNext    = (strobe.first ? '0 : acc) + prodExt;

  // Round half up, then clamp to the output range.
  always_comb begin
    rnd     = {sumNext[ACCW-1], sumNext} + HALF;
    shifted = rnd >>> FRAC;
    if (!shifted[ACCW] && (|shifted[ACCW:DW-1]))
      satVal = {1'b0, {(DW-1){1'b1}}};
    else if (shifted[ACCW] && !(&shifted[ACCW:DW-1]))
      satVal = {1'b1, {(DW-1){1'b0}}};
    else
      satVal = shifted[DW-1:0];
  end

  // Sample ring: one write per period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NTAPS; i++) ring[i] <= '0;
      wrPtr  <= '0;
      curPtr <= '0;
    end else if (strobe.load) begin
      ring[wrPtr] <= inData;
      curPtr      <= wrPtr;
      wrPtr       <= (wrPtr == AW'(NTAPS - 1)) ? '0 : wrPtr + 1'b1;
    end
  end

  // Accumulator and output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (strobe.mac) acc <= sumNext;
      outValid <= strobe.last;
      if (strobe.last) outData <= satVal;
    end
  end

endmodule

// File: rtl/reord_fir.sv
module reord_fir
  import reord_fir_pkg::*;
#(
  parameter int NTAPS   = 24,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int FRAC    = 15,
  parameter int ORD_MUL = 7,
  parameter int ORD_OFS = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [DW-1:0] inData,
  output logic          inReady,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic          busy
);

  localparam int AW = $clog2(NTAPS);

  firStrobe_t    strobe;
  logic [AW-1:0] stepIdx;
  logic [AW-1:0] coefAddr;
  logic [AW-1:0] sampleOfs;

  reord_fir_ctrl #(.NTAPS(NTAPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .busy(busy), .stepIdx(stepIdx), .strobe(strobe)
  );

  reord_fir_order_lut #(.NTAPS(NTAPS), .ORD_MUL(ORD_MUL), .ORD_OFS(ORD_OFS)) u_lut (
    .stepIdx(stepIdx), .coefAddr(coefAddr), .sampleOfs(sampleOfs)
  );

  reord_fir_datapath #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .FRAC(FRAC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .coefAddr(coefAddr), .sampleOfs(sampleOfs),
    .outValid(outValid), .outData(outData)
  );

endmodule

// File: rtl/reord_fir_chk.sv
module reord_fir_chk #(
  parameter int NTAPS = 24,
  localparam int AW = $clog2(NTAPS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inReady,
  input logic          busy,
  input logic          outValid,
  input logic [AW-1:0] stepIdx
);

  // R2: no acceptance in the middle of a period
  a_r2_not_ready_midperiod: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepIdx != AW'(NTAPS - 1)) |-> !inReady);

  // R3: result strobe lasts one cycle
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3: result strobe only after the last step
  a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(busy) && $past(stepIdx) == AW'(NTAPS - 1)));

  // R8: an accepted sample starts a period at step 0
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (busy && stepIdx == '0));

  // R10: an idle engine is always ready
  a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> inReady);

  // R6: step counter stays inside the table
  a_r6_step_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(stepIdx) < NTAPS);

endmodule

bind reord_fir reord_fir_chk #(.NTAPS(NTAPS)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .busy(busy), .outValid(outValid), .stepIdx(stepIdx)
);

// File: tb/reord_fir_tb.sv
`timescale 1ns/1ps
module reord_fir_tb;

  localparam int N  = 24;
  localparam int DW = 16;
  localparam int FRAC = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic inReady, outValid, busy;
  logic [DW-1:0] outData;

  int nCmp = 0;
  int nBad = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  string phase = "R1 reset";

  // Reference model state
  int    hist[$];
  bit    busyM = 1'b0;
  int    stepM = 0;
  bit    valM  = 1'b0;
  int    datM  = 0;
  int    pendY = 0;

  always #4 clk = ~clk;

  reord_fir u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData), .busy(busy)
  );

  // R5 coefficient rule
  function automatic longint coefRef(int j);
    return longint'(((j * 7919 + 1234) % 20001) - 10000);
  endfunction

  // R4/R7/R9: exact sum in index order over the history, zeros before the start
  function automatic int filterRef();
    longint s = 0;
    longint r;
    for (int j = 0; j < N; j++) begin
      longint x = 0;
      if (j < hist.size()) x = longint'(hist[hist.size() - 1 - j]);
      s += coefRef(j) * x;
    end
    r = (s + (longint'(1) <<< (FRAC - 1))) >>> FRAC;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic check(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s [%s] act=%0d exp=%0d t=%0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  // Compare on every clock, away from the active edge, then advance the model.
  always @(negedge clk) begin
    if (running) begin
      bit expReady;
      bit accept;
      expReady = !busyM || (stepM == N - 1);
      check("R2 inReady", int'(inReady), int'(expReady));
      check("R10 busy", int'(busy), int'(busyM));
      check("R3 outValid", int'(outValid), int'(valM));
      if (valM) check("R4 outData", int'($signed(outData)), datM);
      accept = inValid && expReady;
      valM = 1'b0;
      if (busyM && stepM == N - 1) begin
        valM  = 1'b1;
        datM  = pendY;
        busyM = 1'b0;
        stepM = 0;
      end else if (busyM) begin
        stepM++;
      end
      if (accept) begin
        hist.push_back(int'($signed(inData)));
        pendY = filterRef();
        busyM = 1'b1;
        stepM = 0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog [%s] act=timeout exp=done", phase);
    finishRun();
  end

  // Offer one sample and hold it until it is taken.
  task automatic sendSample(int v);
    bit rd;
    inValid = 1'b1;
    inData  = DW'(v);
    do begin
      @(negedge clk);
      rd = inReady;
      @(posedge clk);
      #1;
    end while (!rd);
    inValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R2: junk offered while busy must be ignored.
  task automatic pokeWhileBusy(int cycles);
    inValid = 1'b1;
    inData  = 16'h7fff;
    repeat (cycles) @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 inReady", int'(inReady), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 outValid", int'(outValid), 0);
    check("R1 outData", int'(outData), 0);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);

    // R7/R6/R5: impulse reads each tap once, history starts at zero
    phase = "R6 R7 impulse";
    sendSample(32767);
    for (int i = 0; i < N + 2; i++) sendSample(0);
    idle(5);

    // R8: back-to-back random stream
    phase = "R8 back-to-back";
    for (int i = 0; i < 40; i++) sendSample(int'($signed(16'($urandom))));
    idle(3);

    // R2: idle gaps and junk while busy
    phase = "R2 gaps and ignored input";
    for (int i = 0; i < 15; i++) begin
      sendSample(int'($signed(16'($urandom))));
      pokeWhileBusy(5);
      idle(i % 4 + 19);
    end

    // R9: saturation at both limits
    phase = "R9 saturate high";
    for (int i = 0; i < N; i++) sendSample(coefRef(N - 1 - i) >= 0 ? 32767 : -32768);
    phase = "R9 saturate low";
    for (int i = 0; i < N; i++) sendSample(coefRef(N - 1 - i) >= 0 ? -32768 : 32767);

    // R4: small values exercise rounding of negative sums
    phase = "R4 rounding";
    for (int i = 0; i < 30; i++) sendSample((i % 7) - 3);
    idle(2 * N);

    running = 1'b0;
    finishRun();
  end

endmodule